// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block is the coherence controller of one processor's private, direct-mapped, write-back cache. The cache sits on a broadcast bus shared with peer caches and memory. Every line carries one of three coherence tags: Invalid, Shared (clean, read-only, possibly replicated) or Exclusive (sole copy, writable, dirty). The controller serves single-word CPU reads and writes. It places read-miss, write-miss and write-back transactions on the bus through a request/grant handshake, and it watches the transactions other caches put on the bus.

A CPU access that cannot complete locally stalls until the bus grant arrives. At the grant the line is filled in the same cycle and the CPU is released. When a peer misses on a line this cache holds Exclusive, the controller raises an abort so that memory stays silent, and it drives the dirty word for both the requester and memory. The single shared bus orders all coherence transactions, so every cache sees the writes to one address in the same order.

Top module: `snoop_inv_ctrl`

## Requirements
- R1: After reset every line is Invalid. No CPU ready, bus request or snoop abort is asserted until stimulus arrives, and the first access to any address produces a bus transaction.
- R2: A CPU read whose line is Invalid, or holds another tag, places a read miss (bus command code 1) for the requested address. It returns the bus data to the CPU in the grant cycle and leaves the line Shared.
- R3: A CPU write to an Invalid line places a write miss (bus command code 2). The line becomes Exclusive and holds the written word.
- R4: A CPU write to a Shared line is treated as a miss: it places a write miss (code 2) and the line becomes Exclusive with the written word.
- R5: Read hits on Shared or Exclusive lines, and write hits on Exclusive lines, assert CPU ready with no bus request and no change of coherence state.
- R6: The line index is the low IDX_W address bits and the tag is the rest. A miss that maps to an Exclusive line holding another tag first places a write-back (code 3) with the old address and word, and only then places its own miss.
- R7: A snooped read miss that matches an Exclusive line asserts the abort output, drives the line's word on the supply output, and downgrades the line to Shared.
- R8: A snooped write miss that matches a Shared line invalidates it without an abort. One that matches an Exclusive line aborts, supplies the word, and then invalidates the line.
- R9: A snoop takes priority over a CPU request: while a snoop is presented and this controller is not granted, CPU ready stays low.
- R10: A snoop whose tag does not match, or whose line is Invalid, produces no abort and leaves the line unchanged.
- R11: A pending miss request holds its command and address until granted, and the controller is never granted in a cycle in which it is being snooped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write word |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ready |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant; the transaction completes in the grant cycle |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_rdata | input | DATA_W | Fill word returned in the grant cycle |
| snp_valid | input | 1 | A peer's transaction is on the bus |
| snp_cmd | input | 2 | Peer's bus command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Peer's transaction address |
| snp_abort | output | 1 | This cache supplies the data; memory must not respond |
| snp_data | output | DATA_W | Supplied dirty word |

## Verification
The bound checker watches the bus handshake on every cycle. It checks that hits raise no request, that a write-back is always followed by a miss, that aborts appear only in answer to snooped misses, that a snoop holds the CPU off, and that a pending request is held stable. It also checks that a line which just answered a snoop does not abort the same snoop again. The coherence states themselves are not visible at the ports. Only the bench's two-cache scenarios show them, by replaying the shared-line sequence and then inferring each state from the bus traffic that later accesses do or do not cause, from who supplies data, and from the values returned.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    MS_IDLE   = 2'd0,
    MS_VICTIM = 2'd1,
    MS_MISS   = 2'd2
  } miss_st_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  output line_st_e          ra_st,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output line_st_e          rb_st,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_st_e          wr_st,
  input  logic              wr_fill,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
    end else if (wr_en) begin
      st_q[wr_idx] <= wr_st;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_fill) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign ra_st   = st_q[ra_idx];
  assign ra_tag  = tag_q[ra_idx];
  assign ra_data = data_q[ra_idx];
  assign rb_st   = st_q[rb_idx];
  assign rb_tag  = tag_q[rb_idx];
  assign rb_data = data_q[rb_idx];
endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
  import coh_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid,
  input  bus_cmd_e          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              upd,
  output line_st_e          nxt_st,
  output logic              abort,
  output logic [DATA_W-1:0] supply
);
  logic is_miss;
  logic match;

  always_comb begin
    is_miss = (snp_cmd == BC_RDMISS) || (snp_cmd == BC_WRMISS);
    match   = snp_valid && is_miss && (line_st != LS_INV) && (line_tag == snp_tag);
    upd     = match;
    abort   = match && (line_st == LS_EXC);
    supply  = abort ? line_data : '0;
    nxt_st  = (snp_cmd == BC_WRMISS) ? LS_INV : LS_SHR;
  end
endmodule

// File: rtl/coh_miss_fsm.sv
module coh_miss_fsm
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  logic              snp_busy,
  output logic              bus_req,
  input  logic              bus_gnt,
  output bus_cmd_e          bus_cmd,
  output logic [TAG_W+IDX_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              wr_en,
  output line_st_e          wr_st,
  output logic              wr_fill,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);
  miss_st_e cur_q, nxt;
  logic tag_eq, present, hit, victim;

  always_comb begin
    tag_eq  = (line_tag == cpu_tag);
    present = (line_st != LS_INV) && tag_eq;
    hit     = present && (!cpu_we || (line_st == LS_EXC));
    victim  = (line_st == LS_EXC) && !tag_eq;

    nxt       = cur_q;
    cpu_ready = 1'b0;
    cpu_rdata = line_data;
    bus_req   = 1'b0;
    bus_cmd   = BC_NONE;
    bus_addr  = '0;
    bus_wdata = '0;
    wr_en     = 1'b0;
    wr_st     = line_st;
    wr_fill   = 1'b0;
    wr_tag    = cpu_tag;
    wr_data   = cpu_wdata;

    unique case (cur_q)
      MS_IDLE: begin
        if (cpu_req && !snp_busy) begin
          if (hit) begin
            cpu_ready = 1'b1;
            if (cpu_we) begin
              wr_en   = 1'b1;
              wr_st   = LS_EXC;
              wr_fill = 1'b1;
            end
          end else begin
            nxt = victim ? MS_VICTIM : MS_MISS;
          end
        end
      end
      MS_VICTIM: begin
        if (line_st != LS_EXC) begin
          // ownership already given up to a snoop; memory is current
          nxt = MS_MISS;
        end else begin
          bus_req   = 1'b1;
          bus_cmd   = BC_WBACK;
          bus_addr  = {line_tag, cpu_idx};
          bus_wdata = line_data;
          if (bus_gnt) begin
            wr_en = 1'b1;
            wr_st = LS_INV;
            nxt   = MS_MISS;
          end
        end
      end
      MS_MISS: begin
        bus_req  = 1'b1;
        bus_cmd  = cpu_we ? BC_WRMISS : BC_RDMISS;
        bus_addr = {cpu_tag, cpu_idx};
        if (bus_gnt) begin
          wr_en     = 1'b1;
          wr_st     = cpu_we ? LS_EXC : LS_SHR;
          wr_fill   = 1'b1;
          wr_data   = cpu_we ? cpu_wdata : bus_rdata;
          cpu_ready = 1'b1;
          cpu_rdata = cpu_we ? cpu_wdata : bus_rdata;
          nxt       = MS_IDLE;
        end
      end
      default: nxt = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= MS_IDLE;
    else        cur_q <= nxt;
  end
endmodule

// File: rtl/snoop_inv_ctrl.sv
module snoop_inv_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_abort,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int SYNC_LN = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_LN-1:0] rst_sync_q;
  logic rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LN-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_LN-1];

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  line_st_e          a_st, b_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;

  logic              s_upd, s_abort;
  line_st_e          s_nxt;
  logic [DATA_W-1:0] s_supply;

  logic              f_wr_en, f_wr_fill;
  line_st_e          f_wr_st;
  logic [TAG_W-1:0]  f_wr_tag;
  logic [DATA_W-1:0] f_wr_data;
  bus_cmd_e          f_cmd;

  logic              m_wr_en, m_wr_fill;
  logic [IDX_W-1:0]  m_wr_idx;
  line_st_e          m_wr_st;

  // snoop updates take the single write port ahead of the CPU side
  always_comb begin
    if (s_upd) begin
      m_wr_en   = 1'b1;
      m_wr_idx  = s_idx;
      m_wr_st   = s_nxt;
      m_wr_fill = 1'b0;
    end else begin
      m_wr_en   = f_wr_en;
      m_wr_idx  = c_idx;
      m_wr_st   = f_wr_st;
      m_wr_fill = f_wr_fill;
    end
  end

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ra_idx  (c_idx),
    .ra_st   (a_st),
    .ra_tag  (a_tag),
    .ra_data (a_data),
    .rb_idx  (s_idx),
    .rb_st   (b_st),
    .rb_tag  (b_tag),
    .rb_data (b_data),
    .wr_en   (m_wr_en),
    .wr_idx  (m_wr_idx),
    .wr_st   (m_wr_st),
    .wr_fill (m_wr_fill),
    .wr_tag  (f_wr_tag),
    .wr_data (f_wr_data)
  );

  coh_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (bus_cmd_e'(snp_cmd)),
    .snp_tag   (s_tag),
    .line_st   (b_st),
    .line_tag  (b_tag),
    .line_data (b_data),
    .upd       (s_upd),
    .nxt_st    (s_nxt),
    .abort     (s_abort),
    .supply    (s_supply)
  );

  coh_miss_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_tag   (c_tag),
    .cpu_idx   (c_idx),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .line_st   (a_st),
    .line_tag  (a_tag),
    .line_data (a_data),
    .snp_busy  (snp_valid),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_cmd   (f_cmd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wr_en     (f_wr_en),
    .wr_st     (f_wr_st),
    .wr_fill   (f_wr_fill),
    .wr_tag    (f_wr_tag),
    .wr_data   (f_wr_data)
  );

  assign bus_cmd   = f_cmd;
  assign snp_abort = s_abort;
  assign snp_data  = s_supply;
endmodule

// File: rtl/coh_chk.sv
module coh_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_abort,
  input logic [DATA_W-1:0] snp_data
);
  localparam logic [1:0] C_NONE = 2'd0;
  localparam logic [1:0] C_RD   = 2'd1;
  localparam logic [1:0] C_WR   = 2'd2;
  localparam logic [1:0] C_WB   = 2'd3;

  // R2: an idle bus port shows no command
  a_r2_idle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> bus_cmd == C_NONE);

  // R5: a completion without grant came from a hit and drew no bus request
  a_r5_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !bus_gnt |-> !bus_req);

  // R6: a granted write-back is followed by the miss itself
  a_r6_wb_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt && bus_cmd == C_WB |=> bus_req && (bus_cmd == C_RD || bus_cmd == C_WR));

  // R6: the CPU is never released by the write-back
  a_r6_no_ready_on_wb: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !(bus_gnt && bus_cmd == C_WB));

  // R7: abort only answers a snooped miss
  a_r7_abort_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |-> snp_valid && (snp_cmd == C_RD || snp_cmd == C_WR));

  // R7: after supplying for a read miss the line is Shared and cannot abort it again
  a_r7_downgraded: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort && snp_cmd == C_RD |=>
      !(snp_abort && snp_cmd == C_RD && snp_addr == $past(snp_addr)));

  // R8: after supplying for a write miss the line is gone
  a_r8_invalidated: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort && snp_cmd == C_WR |=> !(snp_abort && snp_addr == $past(snp_addr)));

  // R10: no supply data without an abort
  a_r10_quiet_supply: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_abort |-> snp_data == '0);

  // R9: snoop stalls the CPU side
  a_r9_snoop_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !bus_gnt |-> !cpu_ready);

  // R9: ready only answers a request
  a_r9_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  // R11: a waiting miss keeps its command and address
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && bus_cmd != C_WB |=>
      bus_req && $stable(bus_cmd) && $stable(bus_addr));

  // R11: one bus owner per cycle
  a_r11_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_valid && bus_gnt));
endmodule

bind snoop_inv_ctrl coh_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_ready (cpu_ready),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_cmd   (bus_cmd),
  .bus_addr  (bus_addr),
  .snp_valid (snp_valid),
  .snp_cmd   (snp_cmd),
  .snp_addr  (snp_addr),
  .snp_abort (snp_abort),
  .snp_data  (snp_data)
);

// File: tb/sim_snoop_inv_ctrl.sv
module sim_snoop_inv_ctrl;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 2;
  localparam logic [ADDR_W-1:0] A1 = 8'h05;  // index 1, tag 1
  localparam logic [ADDR_W-1:0] A2 = 8'h09;  // index 1, tag 2
  localparam logic [ADDR_W-1:0] A3 = 8'h06;  // index 2

  logic clk, rst_n;
  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic              req [2];
  logic              we  [2];
  logic [ADDR_W-1:0] addr [2];
  logic [DATA_W-1:0] wd  [2];
  logic              rdy [2];
  logic [DATA_W-1:0] rd  [2];
  logic              breq [2];
  logic              gnt [2];
  logic [1:0]        bcmd [2];
  logic [ADDR_W-1:0] baddr [2];
  logic [DATA_W-1:0] bwd [2];
  logic              sab [2];
  logic [DATA_W-1:0] sdat [2];

  logic              any_gnt, abort_any;
  logic [1:0]        mcmd;
  logic [ADDR_W-1:0] maddr;
  logic [DATA_W-1:0] mwd, sup, brd;
  logic [DATA_W-1:0] mem [256];

  assign gnt[0]    = breq[0];
  assign gnt[1]    = breq[1] && !breq[0];
  assign any_gnt   = gnt[0] || gnt[1];
  assign mcmd      = gnt[0] ? bcmd[0] : (gnt[1] ? bcmd[1] : 2'd0);
  assign maddr     = gnt[0] ? baddr[0] : baddr[1];
  assign mwd       = gnt[0] ? bwd[0] : bwd[1];
  assign abort_any = gnt[0] ? sab[1] : (gnt[1] ? sab[0] : 1'b0);
  assign sup       = gnt[0] ? sdat[1] : sdat[0];
  assign brd       = abort_any ? sup : mem[maddr];

  snoop_inv_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(req[0]), .cpu_we(we[0]), .cpu_addr(addr[0]), .cpu_wdata(wd[0]),
    .cpu_ready(rdy[0]), .cpu_rdata(rd[0]),
    .bus_req(breq[0]), .bus_gnt(gnt[0]), .bus_cmd(bcmd[0]), .bus_addr(baddr[0]),
    .bus_wdata(bwd[0]), .bus_rdata(brd),
    .snp_valid(gnt[1]), .snp_cmd(bcmd[1]), .snp_addr(baddr[1]),
    .snp_abort(sab[0]), .snp_data(sdat[0]));

  snoop_inv_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u1 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(req[1]), .cpu_we(we[1]), .cpu_addr(addr[1]), .cpu_wdata(wd[1]),
    .cpu_ready(rdy[1]), .cpu_rdata(rd[1]),
    .bus_req(breq[1]), .bus_gnt(gnt[1]), .bus_cmd(bcmd[1]), .bus_addr(baddr[1]),
    .bus_wdata(bwd[1]), .bus_rdata(brd),
    .snp_valid(gnt[0]), .snp_cmd(bcmd[0]), .snp_addr(baddr[0]),
    .snp_abort(sab[1]), .snp_data(sdat[1]));

  // memory model and bus log
  int                tx_cnt;
  logic [1:0]        lg_cmd   [8];
  logic              lg_mst   [8];
  logic [ADDR_W-1:0] lg_addr  [8];
  logic [DATA_W-1:0] lg_wdata [8];
  logic              lg_abort [8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= DATA_W'(16'h0A00 | i);
      tx_cnt <= 0;
    end else if (any_gnt) begin
      if (mcmd == 2'd3)   mem[maddr] <= mwd;
      else if (abort_any) mem[maddr] <= sup;
      lg_cmd[tx_cnt % 8]   <= mcmd;
      lg_mst[tx_cnt % 8]   <= gnt[1];
      lg_addr[tx_cnt % 8]  <= maddr;
      lg_wdata[tx_cnt % 8] <= mwd;
      lg_abort[tx_cnt % 8] <= abort_any;
      tx_cnt <= tx_cnt + 1;
    end
  end

  int n_chk, n_fail;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(int p, logic w, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                    output logic [DATA_W-1:0] r, output int ntx, output int t0);
    int guard;
    @(negedge clk);
    t0 = tx_cnt;
    req[p] = 1'b1; we[p] = w; addr[p] = a; wd[p] = d;
    guard = 0;
    #1;
    while (!rdy[p] && guard < 100) begin
      @(negedge clk); #1; guard++;
    end
    if (guard >= 100) chk("R11 access timeout", 32'd1, 32'd0);
    r = rd[p];
    @(negedge clk);
    req[p] = 1'b0;
    ntx = tx_cnt - t0;
  endtask

  function automatic logic [1:0] cmd_at(int t0, int k);
    return lg_cmd[(t0 + k) % 8];
  endfunction

  logic [DATA_W-1:0] r;
  int ntx, t0;

  task automatic t_reset();
    chk("R1 ready0 after reset", 32'(rdy[0]), 32'd0);
    chk("R1 busreq after reset", 32'(breq[0] | breq[1]), 32'd0);
    chk("R1 abort after reset", 32'(sab[0] | sab[1]), 32'd0);
  endtask

  task automatic t_write_invalid();
    op(0, 1'b1, A1, 16'h0010, r, ntx, t0);
    chk("R1 first access uses bus", 32'(ntx), 32'd1);
    chk("R3 write miss cmd", 32'(cmd_at(t0, 0)), 32'd2);
    chk("R3 write miss master", 32'(lg_mst[t0 % 8]), 32'd0);
    chk("R3 no abort", 32'(lg_abort[t0 % 8]), 32'd0);
  endtask

  task automatic t_local_read();
    op(0, 1'b0, A1, 16'h0, r, ntx, t0);
    chk("R5 exclusive read hit data", 32'(r), 32'h10);
    chk("R5 exclusive read hit no bus", 32'(ntx), 32'd0);
  endtask

  task automatic t_remote_read();
    op(1, 1'b0, A1, 16'h0, r, ntx, t0);
    chk("R2 read miss count", 32'(ntx), 32'd1);
    chk("R2 read miss cmd", 32'(cmd_at(t0, 0)), 32'd1);
    chk("R11 miss address", 32'(lg_addr[t0 % 8]), 32'(A1));
    chk("R7 owner aborts", 32'(lg_abort[t0 % 8]), 32'd1);
    chk("R7 supplied data", 32'(r), 32'h10);
    chk("R7 memory updated", 32'(mem[A1]), 32'h10);
  endtask

  task automatic t_remote_write();
    op(1, 1'b1, A1, 16'h0020, r, ntx, t0);
    chk("R4 shared write is miss", 32'(ntx), 32'd1);
    chk("R4 write miss cmd", 32'(cmd_at(t0, 0)), 32'd2);
    chk("R8 shared snoop no abort", 32'(lg_abort[t0 % 8]), 32'd0);
    op(1, 1'b0, A1, 16'h0, r, ntx, t0);
    chk("R4 now exclusive hit", 32'(ntx), 32'd0);
    chk("R4 written data", 32'(r), 32'h20);
  endtask

  task automatic t_victim();
    op(1, 1'b1, A2, 16'h0040, r, ntx, t0);
    chk("R6 two transactions", 32'(ntx), 32'd2);
    chk("R6 write-back first", 32'(cmd_at(t0, 0)), 32'd3);
    chk("R6 write-back address", 32'(lg_addr[t0 % 8]), 32'(A1));
    chk("R6 write-back data", 32'(lg_wdata[t0 % 8]), 32'h20);
    chk("R6 then write miss", 32'(cmd_at(t0, 1)), 32'd2);
    chk("R10 invalid line no abort", 32'(lg_abort[(t0 + 1) % 8]), 32'd0);
    chk("R6 memory holds old block", 32'(mem[A1]), 32'h20);
  endtask

  task automatic t_after_inval();
    op(0, 1'b0, A1, 16'h0, r, ntx, t0);
    chk("R8 invalidated line misses", 32'(ntx), 32'd1);
    chk("R10 tag mismatch no abort", 32'(lg_abort[t0 % 8]), 32'd0);
    chk("R2 fill from memory", 32'(r), 32'h20);
    op(0, 1'b0, A1, 16'h0, r, ntx, t0);
    chk("R5 shared read hit no bus", 32'(ntx), 32'd0);
    chk("R5 shared read hit data", 32'(r), 32'h20);
  endtask

  task automatic t_owner_cycle();
    op(0, 1'b1, A1, 16'h0050, r, ntx, t0);
    chk("R4 shared write miss", 32'(cmd_at(t0, 0)), 32'd2);
    op(0, 1'b1, A1, 16'h0060, r, ntx, t0);
    chk("R5 exclusive write hit no bus", 32'(ntx), 32'd0);
    op(1, 1'b0, A1, 16'h0, r, ntx, t0);
    chk("R6 victim then read", 32'(ntx), 32'd2);
    chk("R6 victim address", 32'(lg_addr[t0 % 8]), 32'(A2));
    chk("R6 victim data", 32'(lg_wdata[t0 % 8]), 32'h40);
    chk("R7 abort on read miss", 32'(lg_abort[(t0 + 1) % 8]), 32'd1);
    chk("R7 supplied latest word", 32'(r), 32'h60);
    op(0, 1'b0, A1, 16'h0, r, ntx, t0);
    chk("R7 downgraded still readable", 32'(ntx), 32'd0);
    op(0, 1'b1, A1, 16'h0070, r, ntx, t0);
    chk("R7 downgraded write needs bus", 32'(ntx), 32'd1);
    chk("R8 peer shared not aborting", 32'(lg_abort[t0 % 8]), 32'd0);
    op(1, 1'b0, A1, 16'h0, r, ntx, t0);
    chk("R8 peer was invalidated", 32'(ntx), 32'd1);
    chk("R7 owner supplies", 32'(r), 32'h70);
  endtask

  task automatic t_snoop_priority();
    @(negedge clk);
    req[1] = 1'b1; we[1] = 1'b0; addr[1] = A3;
    @(negedge clk);
    req[0] = 1'b1; we[0] = 1'b0; addr[0] = A1;
    #1;
    chk("R9 peer granted", 32'(gnt[1]), 32'd1);
    chk("R9 snooped cpu stalled", 32'(rdy[0]), 32'd0);
    chk("R2 peer fill data", 32'(rd[1]), 32'(16'h0A00 | A3));
    @(negedge clk);
    req[1] = 1'b0;
    #1;
    chk("R9 completes after snoop", 32'(rdy[0]), 32'd1);
    chk("R9 data after snoop", 32'(rd[0]), 32'h70);
    @(negedge clk);
    req[0] = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    for (int i = 0; i < 2; i++) begin
      req[i] = 1'b0; we[i] = 1'b0; addr[i] = '0; wd[i] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    t_write_invalid();
    t_local_read();
    t_remote_read();
    t_remote_write();
    t_victim();
    t_after_inval();
    t_owner_cycle();
    t_snoop_priority();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule